// File: doc/BRIEF.md
# Position Counter with Latches and Output Control

This block wraps a 32-bit up/down position counter with the capture and output logic that a controller steers through one 8-bit control byte. Feedback comes back through an 8-bit status byte. The controller can preset the counter with a handshake. It can arm a one-shot capture of the counter on a zero-mark input, and it can measure a workpiece by capturing the counter on both edges of a gate input. It also drives one digital output, either by hand or from a compare against a programmed value.

The count strobes come from an upstream decoder, one step per clock at most. The zero-mark and gate inputs are asynchronous. Each passes through a two-flop synchronizer before its edges are detected. All control and status pins are plain levels sampled on every clock: there is no data stream, and so there is no back-pressure.

Control byte bits, from bit 7 down to bit 0:
- 7: mode select
- 6: compare enable
- 5: manual output level
- 4: falling-edge capture select
- 3: rising-edge capture select
- 2: preset request
- 1: measurement disable (active high)
- 0: zero-mark arm

Status byte bits, from bit 7 down to bit 0:
- 7: mode echo
- 6: reserved, reads 0
- 5: output level
- 4: gate level
- 3: zero input level
- 2: preset acknowledge
- 1: measurement done
- 0: zero-mark captured

Top module: `poscnt_ctrl`

## Requirements
- R1: After reset the counter, all three latch registers, the output and every status byte bit are 0.
- R2: On a clock where only the up strobe is high, the counter adds 1. Where only the down strobe is high, it subtracts 1. With both strobes high or both low, the counter holds. The counter wraps modulo 2^32 in both directions.
- R3: A rising edge of control bit 2 loads the preset word at that clock. The preset overrides any count strobe at that clock. Status bit 2 becomes 1 at the same clock and stays 1 until control bit 2 is cleared, then falls one clock later. Holding control bit 2 high does not load the counter again.
- R4: While control bit 0 is 1, the first synchronized rising edge of the zero input stores the counter in the zero latch and sets status bit 0. Later edges leave the zero latch unchanged.
- R5: Clearing control bit 0 clears status bit 0 one clock later and re-arms the zero-mark capture, so that a new capture can happen after the bit is set again.
- R6: Status bit 3 shows the zero input level, and status bit 4 shows the gate input level. Each appears two clocks after the input changes.
- R7: With control bit 6 at 0, the output takes the value of control bit 5 one clock later. Status bit 5 always equals the output.
- R8: With control bit 6 at 1, control bit 5 is ignored. A single up step that brings the counter to the compare value sets the output. A single down step that brings it to the compare value clears the output. Otherwise the output holds.
- R9: With control bit 1 at 0, measurement is enabled. If bit 3 is set, the first gate rising edge stores the counter in the rise latch. If bit 4 is set, the first gate falling edge stores it in the fall latch. Status bit 1 becomes 1 once both latches have been captured. Setting control bit 1 to 1 clears status bit 1 and re-arms both captures.
- R10: While control bit 0 is 1, gate edges capture nothing, even with measurement enabled.
- R11: Status bit 7 echoes control bit 7 (0 in process data mode). Status bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_byte | input | 8 | Control byte |
| preset_val | input | 32 | Value loaded on a preset request |
| cmp_val | input | 32 | Compare value for output control |
| cnt_up | input | 1 | Count-up strobe |
| cnt_dn | input | 1 | Count-down strobe |
| zero_in | input | 1 | Asynchronous zero-mark input |
| gate_in | input | 1 | Asynchronous gate input |
| status_byte | output | 8 | Status byte |
| count | output | 32 | Current counter value |
| zero_latch | output | 32 | Counter captured at the zero mark |
| rise_latch | output | 32 | Counter captured at gate rising edge |
| fall_latch | output | 32 | Counter captured at gate falling edge |
| out_pin | output | 1 | Digital output |

## Verification
The bench walks the counter across the 2^32 wrap in both directions and applies both strobes at once. A design that wrapped wrongly, or let one strobe win, would show the wrong count. The bench holds the preset request high with a new preset word and also presets on a clock that carries a count strobe, which catches a design that reloads on the level or lets counting beat the preset. It sends a second zero pulse and a second gate pulse after each capture, and it enables the zero-mark capture and the gate captures together. Those steps expose a latch that captures more than once, and gate latches that are not locked out by the zero-mark arm. Toggling the manual level in compare mode, and stepping the counter up and then down through the compare value, shows whether the manual bit leaks through or a direction is confused.

// File: rtl/poscnt_pkg.sv
package poscnt_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic mode_sel;
    logic cmp_en;
    logic man_out;
    logic fall_sel;
    logic rise_sel;
    logic preset_req;
    logic meas_off;
    logic zero_arm;
  } ctrl_t;

  typedef struct packed {
    logic mode_ack;
    logic rsvd;
    logic out_lvl;
    logic gate_lvl;
    logic zero_lvl;
    logic preset_ack;
    logic meas_done;
    logic zero_done;
  } stat_t;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
  assign fall  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/cnt_core.sv
module cnt_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up,
  input  logic         dn,
  input  logic         preset_req,
  input  logic [W-1:0] preset_val,
  output logic [W-1:0] count,
  output logic         preset_ack,
  output logic         step_up,
  output logic         step_dn
);
  logic preset_prev;
  logic preset_edge;

  assign preset_edge = preset_req & ~preset_prev;
  assign step_up     = up & ~dn & ~preset_edge;
  assign step_dn     = dn & ~up & ~preset_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count       <= '0;
      preset_prev <= 1'b0;
      preset_ack  <= 1'b0;
    end else begin
      preset_prev <= preset_req;
      if (preset_edge)  count <= preset_val;
      else if (step_up) count <= count + W'(1);
      else if (step_dn) count <= count - W'(1);
      if (!preset_req)      preset_ack <= 1'b0;
      else if (preset_edge) preset_ack <= 1'b1;
    end
  end

  // R3
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_req && !preset_prev) |=> (count == $past(preset_val) && preset_ack));

  // R2
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn && !(preset_req && !preset_prev)) |=> count == $past(count) + W'(1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up == dn && !(preset_req && !preset_prev)) |=> $stable(count));
endmodule

// File: rtl/zero_latch_unit.sv
module zero_latch_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         zrise,
  input  logic [W-1:0] count,
  output logic [W-1:0] latch_q,
  output logic         done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      done    <= 1'b0;
    end else if (!arm) begin
      done <= 1'b0;
    end else if (zrise && !done) begin
      latch_q <= count;
      done    <= 1'b1;
    end
  end

  // R4
  zero_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && arm) |=> $stable(latch_q));

  // R5
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !done);
endmodule

// File: rtl/meas_unit.sv
module meas_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         meas_off,
  input  logic         zero_arm,
  input  logic         rise_sel,
  input  logic         fall_sel,
  input  logic         g_rise,
  input  logic         g_fall,
  input  logic [W-1:0] count,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic         done
);
  logic got_r, got_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      got_r  <= 1'b0;
      got_f  <= 1'b0;
    end else if (meas_off) begin
      got_r <= 1'b0;
      got_f <= 1'b0;
    end else if (!zero_arm) begin
      if (rise_sel && g_rise && !got_r) begin
        rise_q <= count;
        got_r  <= 1'b1;
      end
      if (fall_sel && g_fall && !got_f) begin
        fall_q <= count;
        got_f  <= 1'b1;
      end
    end
  end

  assign done = got_r & got_f;

  // R10
  gate_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_arm |=> ($stable(rise_q) && $stable(fall_q)));

  // R9
  meas_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_off |=> !done);
endmodule

// File: rtl/out_unit.sv
module out_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_en,
  input  logic         man_out,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp_val,
  output logic         out_q
);
  logic hit_up, hit_dn;

  assign hit_up = step_up && (count + W'(1) == cmp_val);
  assign hit_dn = step_dn && (count - W'(1) == cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n)       out_q <= 1'b0;
    else if (!cmp_en) out_q <= man_out;
    else if (hit_up)  out_q <= 1'b1;
    else if (hit_dn)  out_q <= 1'b0;
  end

  // R7
  manual_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> out_q == $past(man_out));

  // R8
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && !step_up && !step_dn) |=> $stable(out_q));
endmodule

// File: rtl/poscnt_ctrl.sv
module poscnt_ctrl
  import poscnt_pkg::*;
#(
  parameter int W        = 32,
  parameter int SYNC_STG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   ctrl_byte,
  input  logic [W-1:0] preset_val,
  input  logic [W-1:0] cmp_val,
  input  logic         cnt_up,
  input  logic         cnt_dn,
  input  logic         zero_in,
  input  logic         gate_in,
  output logic [7:0]   status_byte,
  output logic [W-1:0] count,
  output logic [W-1:0] zero_latch,
  output logic [W-1:0] rise_latch,
  output logic [W-1:0] fall_latch,
  output logic         out_pin
);
  localparam int N_IN = 2;

  ctrl_t c;
  stat_t s;
  assign c = ctrl_t'(ctrl_byte);

  logic [N_IN-1:0] raw_in, lvl, rse, fll;
  assign raw_in = {gate_in, zero_in};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    sync_edge #(.STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw_in[i]),
      .level(lvl[i]), .rise(rse[i]), .fall(fll[i])
    );
  end

  logic preset_ack, step_up, step_dn, zero_done, meas_done;

  cnt_core #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .up(cnt_up), .dn(cnt_dn),
    .preset_req(c.preset_req), .preset_val(preset_val),
    .count(count), .preset_ack(preset_ack),
    .step_up(step_up), .step_dn(step_dn)
  );

  zero_latch_unit #(.W(W)) u_zero (
    .clk(clk), .rst_n(rst_n), .arm(c.zero_arm), .zrise(rse[0]),
    .count(count), .latch_q(zero_latch), .done(zero_done)
  );

  meas_unit #(.W(W)) u_meas (
    .clk(clk), .rst_n(rst_n), .meas_off(c.meas_off), .zero_arm(c.zero_arm),
    .rise_sel(c.rise_sel), .fall_sel(c.fall_sel),
    .g_rise(rse[1]), .g_fall(fll[1]), .count(count),
    .rise_q(rise_latch), .fall_q(fall_latch), .done(meas_done)
  );

  out_unit #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .cmp_en(c.cmp_en), .man_out(c.man_out),
    .step_up(step_up), .step_dn(step_dn), .count(count),
    .cmp_val(cmp_val), .out_q(out_pin)
  );

  logic unused_fall0;
  assign unused_fall0 = fll[0];

  always_comb begin
    s            = '0;
    s.mode_ack   = c.mode_sel;
    s.rsvd       = 1'b0;
    s.out_lvl    = out_pin;
    s.gate_lvl   = lvl[1];
    s.zero_lvl   = lvl[0];
    s.preset_ack = preset_ack;
    s.meas_done  = meas_done;
    s.zero_done  = zero_done;
  end
  assign status_byte = s;
endmodule

// File: tb/poscnt_ctrl_tb.sv
module poscnt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  ctrl_byte = '0;
  logic [31:0] preset_val = '0, cmp_val = '0;
  logic        cnt_up = 0, cnt_dn = 0, zero_in = 0, gate_in = 0;
  logic [7:0]  status_byte;
  logic [31:0] count, zero_latch, rise_latch, fall_latch;
  logic        out_pin;

  int checks = 0, errors = 0;

  poscnt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .preset_val(preset_val),
    .cmp_val(cmp_val), .cnt_up(cnt_up), .cnt_dn(cnt_dn), .zero_in(zero_in),
    .gate_in(gate_in), .status_byte(status_byte), .count(count),
    .zero_latch(zero_latch), .rise_latch(rise_latch), .fall_latch(fall_latch),
    .out_pin(out_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // up, dn, expected count; starts from a preset of FFFF_FFFE
  localparam logic [33:0] VEC [0:7] = '{
    {1'b1, 1'b0, 32'hFFFF_FFFF},
    {1'b1, 1'b0, 32'h0000_0000},
    {1'b1, 1'b0, 32'h0000_0001},
    {1'b1, 1'b1, 32'h0000_0001},
    {1'b0, 1'b0, 32'h0000_0001},
    {1'b0, 1'b1, 32'h0000_0000},
    {1'b0, 1'b1, 32'hFFFF_FFFF},
    {1'b0, 1'b1, 32'hFFFF_FFFE}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic steps_up(input int n);
    cnt_up = 1; tick(n); cnt_up = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1 status", {24'h0, status_byte}, 32'h0);
    chk("R1 count", count, 32'h0);
    chk("R1 zero latch", zero_latch, 32'h0);
    chk("R1 rise latch", rise_latch, 32'h0);
    chk("R1 fall latch", fall_latch, 32'h0);
    chk("R1 out", {31'h0, out_pin}, 32'h0);

    // R3 preset with handshake
    preset_val = 32'hFFFF_FFFE; ctrl_byte[2] = 1; tick(1);
    chk("R3 load", count, 32'hFFFF_FFFE);
    chk("R3 ack set", {31'h0, status_byte[2]}, 32'h1);
    preset_val = 32'h5; tick(2);
    chk("R3 no reload on level", count, 32'hFFFF_FFFE);
    ctrl_byte[2] = 0; tick(1);
    chk("R3 ack cleared", {31'h0, status_byte[2]}, 32'h0);

    // R2 table of count steps across the wrap
    for (int i = 0; i < 8; i++) begin
      cnt_up = VEC[i][33]; cnt_dn = VEC[i][32];
      tick(1);
      chk("R2 count step", count, VEC[i][31:0]);
    end
    cnt_up = 0; cnt_dn = 0;

    // R3 preset beats a count strobe
    preset_val = 32'd100; ctrl_byte[2] = 1; cnt_up = 1; tick(1);
    cnt_up = 0;
    chk("R3 preset over strobe", count, 32'd100);
    ctrl_byte[2] = 0; tick(1);

    // R11 mode echo and reserved bit
    chk("R11 bits 7:6", {30'h0, status_byte[7:6]}, 32'h0);

    // R4 zero-mark capture, R6 level
    ctrl_byte[0] = 1; tick(1);
    zero_in = 1; tick(2);
    chk("R6 zero level", {31'h0, status_byte[3]}, 32'h1);
    tick(1);
    chk("R4 zero capture", zero_latch, 32'd100);
    chk("R4 zero flag", {31'h0, status_byte[0]}, 32'h1);
    zero_in = 0; tick(3);
    steps_up(3);
    zero_in = 1; tick(3); zero_in = 0; tick(3);
    chk("R4 second pulse ignored", zero_latch, 32'd100);

    // R5 re-arm
    ctrl_byte[0] = 0; tick(1);
    chk("R5 flag cleared", {31'h0, status_byte[0]}, 32'h0);
    ctrl_byte[0] = 1; tick(1);
    zero_in = 1; tick(3);
    chk("R5 re-armed capture", zero_latch, 32'd103);
    zero_in = 0; tick(3);

    // R10 gate lockout while zero arm set, measurement enabled
    ctrl_byte[4] = 1; ctrl_byte[3] = 1; ctrl_byte[1] = 0; tick(1);
    gate_in = 1; tick(2);
    chk("R6 gate level", {31'h0, status_byte[4]}, 32'h1);
    tick(1); gate_in = 0; tick(3);
    chk("R10 rise locked", rise_latch, 32'h0);
    chk("R10 fall locked", fall_latch, 32'h0);
    chk("R10 no done", {31'h0, status_byte[1]}, 32'h0);

    // R9 measurement
    ctrl_byte[0] = 0; tick(1);
    gate_in = 1; tick(3);
    chk("R9 rise capture", rise_latch, 32'd103);
    chk("R9 not yet done", {31'h0, status_byte[1]}, 32'h0);
    steps_up(2);
    gate_in = 0; tick(3);
    chk("R9 fall capture", fall_latch, 32'd105);
    chk("R9 done", {31'h0, status_byte[1]}, 32'h1);
    steps_up(1);
    gate_in = 1; tick(3); gate_in = 0; tick(3);
    chk("R9 first edge only", rise_latch, 32'd103);
    ctrl_byte[1] = 1; tick(1);
    chk("R9 done cleared", {31'h0, status_byte[1]}, 32'h0);

    // R7 manual output
    ctrl_byte[6] = 0; ctrl_byte[5] = 1; tick(1);
    chk("R7 out high", {31'h0, out_pin}, 32'h1);
    chk("R7 status out", {31'h0, status_byte[5]}, 32'h1);
    ctrl_byte[5] = 0; tick(1);
    chk("R7 out low", {31'h0, out_pin}, 32'h0);

    // R8 compare: count 106, compare at 108
    cmp_val = 32'd108; ctrl_byte[6] = 1; ctrl_byte[5] = 1; tick(1);
    chk("R8 manual ignored", {31'h0, out_pin}, 32'h0);
    steps_up(1);
    chk("R8 below compare", {31'h0, out_pin}, 32'h0);
    steps_up(1);
    chk("R8 set on up hit", {31'h0, out_pin}, 32'h1);
    ctrl_byte[5] = 0; steps_up(1);
    chk("R8 hold past compare", {31'h0, out_pin}, 32'h1);
    cnt_dn = 1; tick(1); cnt_dn = 0;
    chk("R8 count at compare", count, 32'd108);
    chk("R8 clear on down hit", {31'h0, out_pin}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule